// File: doc/BRIEF.md
# Note Duration Timer

This block measures how long each note of a tune is held. A sequencer raises `note_start` for one cycle when a note begins and supplies a 2-bit duration code with it. The block answers with a single-cycle `note_done` pulse when the note's time is up, and the sequencer then moves to the next note. Pitch generation and note storage belong to other blocks.

Time is built up in three stages. A 9-bit binary prescaler divides the clock by 512. A 4-bit tempo LFSR divides those prescaler ticks by a ratio of 1 to 15, fixed by a parameter. A 4-bit beat LFSR counts tempo ticks. At the start of each note it is loaded from a four-entry rhythm table indexed by the duration code. Neither LFSR compares against a count. Each is loaded with a start pattern and stepped until it reaches a fixed terminal pattern, so the start pattern alone sets the length. For quick production testing, a test-mode input bypasses the prescaler, and every note then ends 512 times sooner.

Top module: `note_len_timer`

## Requirements
- R1: While reset is held, and afterwards until the first `note_start`, `note_done` stays low.
- R2: Each LFSR step shifts the state one place toward bit 0 and puts bit1 XOR bit0 into bit 3. The terminal pattern is 4'b1000. The distance d(v) is the number of steps it takes to go from v to 4'b1000, with at least one step taken, so d(4'b1000) = 15.
- R3: The tempo divider emits one tempo tick per d(TEMPO_PRESET) prescaler ticks. It reloads its preset on each tempo tick, at reset and at `note_start`.
- R4: With `test_mode` low, the prescaler ticks once every 512 clocks. `note_done` is therefore high in the cycle that follows the clock edge 512·d(TEMPO_PRESET)·d(R) edges after the edge that sampled `note_start`, where R is the selected rhythm entry.
- R5: Duration code c (0 to 3) selects parameter RHYTHM_c. The defaults are 4'b0001, 4'b0011, 4'b1111 and 4'b0101, which give 1, 2, 4 and 8 tempo ticks.
- R6: With `test_mode` high, the prescaler ticks on every clock, so the note length becomes d(TEMPO_PRESET)·d(R) clocks.
- R7: `note_done` lasts exactly one cycle. No further pulse follows until the next `note_start`.
- R8: A `note_start` during a note restarts the timing from that edge, using the new code. A `note_start` sampled on the edge where the note would have ended suppresses that pulse.
- R9: Reset during a note cancels it, and no `note_done` follows.
- R10: `note_start` also clears the prescaler, so a note's length does not depend on when it starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dur_code | input | 2 | Duration code, sampled with note_start |
| note_start | input | 1 | One-cycle strobe that begins a note |
| test_mode | input | 1 | Bypasses the divide-by-512 prescaler |
| note_done | output | 1 | One-cycle pulse at the end of the note |

## Verification
The bench builds the block with TEMPO_PRESET = 4'b1000 and RHYTHM_3 = 4'b1000. Both therefore take the full 15-step cycle, which puts the longest tempo ratio and the longest beat count within reach. The other rhythm entries keep their defaults (1, 2 and 4 ticks). In test mode this gives exact lengths of 15, 30, 60 and 225 clocks. Three normal-mode notes of 7680, 15360 and 30720 clocks confirm the 512 prescaler. Directed cases cover the restart rules, reset partway through a note and silence while idle.

// File: rtl/note_len_pkg.sv
package note_len_pkg;

    localparam int           LFSR_W    = 4;
    localparam logic [3:0]   LFSR_TERM = 4'b1000;

    // One LFSR step: shift toward bit 0, feed bit1^bit0 into bit 3.
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[1] ^ s[0], s[LFSR_W-1:1]};
    endfunction

endpackage

// File: rtl/nlt_prescaler.sv
module nlt_prescaler #(
    parameter int PRE_BITS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic bypass,
    output logic tick
);
    localparam logic [PRE_BITS-1:0] PRE_LAST = {PRE_BITS{1'b1}};

    typedef struct packed {
        logic [PRE_BITS-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) st_d.cnt = '0;
        else         st_d.cnt = st_q.cnt + 1'b1;
        tick = bypass | (st_q.cnt == PRE_LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nlt_tempo_div.sv
module nlt_tempo_div
    import note_len_pkg::*;
#(
    parameter logic [LFSR_W-1:0] PRESET = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic              tick,
    output logic [LFSR_W-1:0] state
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } tempo_state_t;

    tempo_state_t st_d, st_q;
    logic [LFSR_W-1:0] nxt;

    always_comb begin
        st_d  = st_q;
        nxt   = lfsr_next(st_q.lfsr);
        tick  = step && !restart && (nxt == LFSR_TERM);
        if (restart)   st_d.lfsr = PRESET;
        else if (tick) st_d.lfsr = PRESET;
        else if (step) st_d.lfsr = nxt;
        state = st_q.lfsr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.lfsr <= PRESET;
        else        st_q      <= st_d;
    end
endmodule

// File: rtl/nlt_beat_lfsr.sv
module nlt_beat_lfsr
    import note_len_pkg::*;
#(
    parameter int                    CODE_W = 2,
    parameter logic [(LFSR_W<<CODE_W)-1:0] TABLE = 16'h5F31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic              step,
    output logic              done,
    output logic [LFSR_W-1:0] state
);
    localparam int ENTRIES = 1 << CODE_W;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic              active;
        logic              done;
    } beat_state_t;

    beat_state_t st_d, st_q;
    logic [LFSR_W-1:0] entry [ENTRIES];
    logic [LFSR_W-1:0] nxt;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_table
        assign entry[g] = TABLE[g*LFSR_W +: LFSR_W];
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        nxt       = lfsr_next(st_q.lfsr);
        if (start) begin
            st_d.lfsr   = entry[code];
            st_d.active = 1'b1;
        end else if (st_q.active && step) begin
            st_d.lfsr = nxt;
            if (nxt == LFSR_TERM) begin
                st_d.done   = 1'b1;
                st_d.active = 1'b0;
            end
        end
        done  = st_q.done;
        state = st_q.lfsr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lfsr   <= entry[0];
            st_q.active <= 1'b0;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/note_len_timer.sv
module note_len_timer
    import note_len_pkg::*;
#(
    parameter int          PRE_BITS     = 9,
    parameter logic [3:0]  TEMPO_PRESET = 4'b0011,
    parameter logic [3:0]  RHYTHM_0     = 4'b0001,
    parameter logic [3:0]  RHYTHM_1     = 4'b0011,
    parameter logic [3:0]  RHYTHM_2     = 4'b1111,
    parameter logic [3:0]  RHYTHM_3     = 4'b0101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] dur_code,
    input  logic       note_start,
    input  logic       test_mode,
    output logic       note_done
);
    localparam int                  CODE_W = 2;
    localparam logic [15:0]         RHYTHM_TABLE = {RHYTHM_3, RHYTHM_2, RHYTHM_1, RHYTHM_0};

    logic              pre_tick;
    logic              tempo_tick;
    logic [LFSR_W-1:0] tempo_state;
    logic [LFSR_W-1:0] beat_state;

    nlt_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (note_start),
        .bypass  (test_mode),
        .tick    (pre_tick)
    );

    nlt_tempo_div #(.PRESET(TEMPO_PRESET)) u_tempo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (note_start),
        .step    (pre_tick),
        .tick    (tempo_tick),
        .state   (tempo_state)
    );

    nlt_beat_lfsr #(.CODE_W(CODE_W), .TABLE(RHYTHM_TABLE)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (note_start),
        .code    (dur_code),
        .step    (tempo_tick),
        .done    (note_done),
        .state   (beat_state)
    );
endmodule

// File: rtl/note_len_timer_chk.sv
module note_len_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       note_start,
    input logic       test_mode,
    input logic       note_done,
    input logic       pre_tick,
    input logic       tempo_tick,
    input logic [3:0] tempo_state,
    input logic [3:0] beat_state
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_done |=> !note_done);

    // R8
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_start |=> !note_done);

    // R4
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && !test_mode) |=> (test_mode || !pre_tick));

    // R3
    tempo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_tick && !note_start) |=> $stable(tempo_state));

    // R2
    tempo_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tempo_state != 4'b0000);

    // R5
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tempo_tick && !note_start) |=> $stable(beat_state));
endmodule

bind note_len_timer note_len_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .note_start  (note_start),
    .test_mode   (test_mode),
    .note_done   (note_done),
    .pre_tick    (pre_tick),
    .tempo_tick  (tempo_tick),
    .tempo_state (tempo_state),
    .beat_state  (beat_state)
);

// File: tb/note_len_timer_bench.sv
module note_len_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dur_code = 2'd0;
    logic       note_start = 1'b0;
    logic       test_mode = 1'b0;
    logic       note_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    note_len_timer #(
        .TEMPO_PRESET (4'b1000),
        .RHYTHM_3     (4'b1000)
    ) u_note_len_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .dur_code   (dur_code),
        .note_start (note_start),
        .test_mode  (test_mode),
        .note_done  (note_done)
    );

    // Vector: {code[1:0], test_mode, length[16:0]}; tempo ratio 15, beats 1,2,4,15
    localparam int NVEC = 7;
    localparam logic [19:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 17'd15},
        {2'd1, 1'b1, 17'd30},
        {2'd2, 1'b1, 17'd60},
        {2'd3, 1'b1, 17'd225},
        {2'd0, 1'b0, 17'd7680},
        {2'd1, 1'b0, 17'd15360},
        {2'd2, 1'b0, 17'd30720}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Counts edges after the start edge until note_done is seen
    task automatic wait_done(input int exp_len, input string req);
        int n = 0;
        bit seen = 1'b0;
        while (n < exp_len + 20 && !seen) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (note_done) seen = 1'b1;
        end
        check(seen && n == exp_len, req, seen ? n : -1, exp_len);
        @(negedge clk);
        check(!note_done, "R7 pulse width", note_done, 0);
    endtask

    task automatic start_note(input logic [1:0] code, input bit tm);
        @(negedge clk);
        dur_code   = code;
        test_mode  = tm;
        note_start = 1'b1;
        @(negedge clk);
        note_start = 1'b0;
    endtask

    task automatic watch_quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (note_done) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(!note_done, "R1 during reset", note_done, 0);
        rst_n = 1'b1;
        test_mode = 1'b1;
        watch_quiet(300, "R1 idle after reset");

        // R4 R5 R6: vector table
        for (int v = 0; v < NVEC; v++) begin
            start_note(VEC[v][19:18], VEC[v][17]);
            wait_done(int'(VEC[v][16:0]), VEC[v][17] ? "R6 test-mode length" : "R4 normal length");
        end

        // R7: stays idle after a finished note
        start_note(2'd1, 1'b1);
        wait_done(30, "R5 code1 length");
        watch_quiet(300, "R7 no repeat pulse");

        // R8: restart mid-note with a new code
        start_note(2'd3, 1'b1);
        repeat (100) @(negedge clk);
        check(!note_done, "R8 before restart", note_done, 0);
        start_note(2'd0, 1'b1);
        wait_done(15, "R8 restart length");

        // R8: start on the finishing edge suppresses the pulse
        start_note(2'd0, 1'b1);
        repeat (14) @(negedge clk);
        check(!note_done, "R8 early", note_done, 0);
        note_start = 1'b1;
        @(negedge clk);
        check(!note_done, "R8 suppressed pulse", note_done, 0);
        note_start = 1'b0;
        wait_done(15, "R8 length after collision");

        // R10: prescaler phase does not affect normal-mode length
        test_mode = 1'b0;
        repeat (137) @(negedge clk);
        start_note(2'd0, 1'b0);
        wait_done(7680, "R10 aligned length");

        // R9: reset during a note cancels it
        start_note(2'd3, 1'b1);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!note_done, "R9 during reset", note_done, 0);
        rst_n = 1'b1;
        watch_quiet(300, "R9 no pulse after abort");

        finish_run();
    end
endmodule